// File: doc/BRIEF.md
# Per-Core Countdown Timer with Power-of-Two Prescaler

This block is a countdown timer for a single core. The bus clock passes through a prescaler whose ratio is a power of two, from 1 to 128. Each divided tick lowers a current-count register by one. Software controls the timer through six word-wide registers, selected by a small index:

- a control word that holds a global enable;
- an entry word that holds the interrupt vector, a mask flag and a reload-mode flag;
- the starting count;
- the live count, which is read-only;
- the prescaler code;
- an acknowledge port.

Writing a starting count loads the live count and restarts the prescaler. When the count runs out, the block raises a request that carries the programmed vector, unless the entry is masked. The request stays up until software acknowledges it. In reload mode the count starts again from the starting value. In single-shot mode it stays at zero.

The prescaler code is three bits, held in two fields that are not next to each other in the divide register. The mapping is rotated, so that code 7 means no division and code 0 means divide by two. The logic that accepts the request and ranks it against other interrupt sources lies outside this block.

Top module: `lcl_tick_timer`

## Requirements
- R1: After reset, the following hold: the live count and the starting count are 0; the entry word reads 0x0001_0000 (mask set, vector 0, single-shot); the control word and the divide register read 0; `irq_req` is low.
- R2: The prescaler code is formed as divide-register bits [1:0] plus bit 3 shifted to position 2. The division ratio is 1 << ((code + 1) mod 8), so code 7 divides by 1, code 0 by 2 and code 3 by 16.
- R3: The divide register (index 4) reads back only bits 1:0 and bit 3; bit 2 and bits 31:4 read 0.
- R4: A write to the starting count (index 2) sets the live count to the written value on the next clock and clears the prescaler. Writing 0 stops the timer at 0.
- R5: While the timer is enabled and the live count (index 3) is non-zero, the live count falls by one once every ratio cycles. The first decrement comes ratio cycles after the load.
- R6: In single-shot mode (entry bit 17 clear), a tick at count 1 leaves the count at 0, where it stays until the next load.
- R7: In reload mode (entry bit 17 set), a tick at count 1 reloads the starting count.
- R8: A tick at count 1 sets `irq_req` only if entry bit 16 (mask) is clear. `irq_vector` always shows entry bits [7:0].
- R9: A write of any value to index 5 clears `irq_req`, unless an expiry happens in the same cycle.
- R10: While control bit 0 (enable) is clear, the prescaler and the live count are frozen, and no request is raised.
- R11: The control word (index 0, bit 0), the entry word (bits [7:0], 16 and 17) and the starting count (index 2) read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_req | output | 1 | Pending timer request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The hardest case to reach is the last prescaler tick arriving at count 1 at the same time as a register write: an acknowledge, a change of mode or mask, or a new divide code. In that cycle the old entry fields must decide the outcome, and the setting of the request must take priority over the acknowledge. Directed loads with small counts and the divide-by-1 code make expiries frequent. After that, a long stretch of random writes with small counts and random divide codes lands writes on expiry cycles many times. A behavioural model checks the request, the vector and the read data on every cycle.

// File: rtl/lcl_tmr_pkg.sv
package lcl_tmr_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int VEC_W    = 8;
    localparam int CODE_W   = 3;

    localparam logic [ADDR_W-1:0] IDX_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] IDX_LVT  = 3'd1;
    localparam logic [ADDR_W-1:0] IDX_INIT = 3'd2;
    localparam logic [ADDR_W-1:0] IDX_CUR  = 3'd3;
    localparam logic [ADDR_W-1:0] IDX_DIV  = 3'd4;
    localparam logic [ADDR_W-1:0] IDX_ACK  = 3'd5;

    localparam int LVT_MASK_BIT = 16;
    localparam int LVT_PER_BIT  = 17;
    localparam int DIV_HI_BIT   = 3;

    // rotated mapping: the shift amount is code + 1, wrapping at 2**CODE_W
    function automatic logic [CODE_W-1:0] div_shift(input logic [CODE_W-1:0] code);
        return code + 1'b1;
    endfunction
endpackage

// File: rtl/lcl_tmr_prescale.sv
module lcl_tmr_prescale #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int PRE_W = (1 << CODE_W) - 1;

    logic [PRE_W-1:0]  pre_d, pre_q, sel_mask;
    logic [CODE_W-1:0] shift;

    always_comb begin
        shift = lcl_tmr_pkg::div_shift(code);
        for (int i = 0; i < PRE_W; i++) begin
            sel_mask[i] = (i < int'(shift));
        end
        tick  = run && ((pre_q & sel_mask) == sel_mask);
        pre_d = pre_q;
        if (restart)  pre_d = '0;
        else if (run) pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/lcl_tmr_down.sv
module lcl_tmr_down #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cur,
    output logic             expire
);
    logic [CNT_W-1:0] cur_d, cur_q;

    always_comb begin
        expire = tick && (cur_q == CNT_W'(1));
        cur_d  = cur_q;
        if (load)        cur_d = load_val;
        else if (expire) cur_d = periodic ? reload_val : '0;
        else if (tick)   cur_d = cur_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign cur = cur_q;
endmodule

// File: rtl/lcl_tick_timer.sv
module lcl_tick_timer
    import lcl_tmr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_req,
    output logic [VW-1:0] irq_vector
);
    typedef struct packed {
        logic              en;
        logic [VW-1:0]     vec;
        logic              mask;
        logic              periodic;
        logic [DW-1:0]     init;
        logic [1:0]        dlo;
        logic              dhi;
        logic              pend;
    } tmr_state_t;

    tmr_state_t    st_d, st_q;
    logic          load, run, tick, expire;
    logic [DW-1:0] cur;
    logic [CODE_W-1:0] code;

    assign load = reg_we && (reg_addr == IDX_INIT);
    assign run  = st_q.en && (cur != '0) && !load;
    assign code = {st_q.dhi, st_q.dlo};

    lcl_tmr_prescale #(.CODE_W(CODE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(load), .run(run),
        .code(code), .tick(tick)
    );

    lcl_tmr_down #(.CNT_W(DW)) u_down (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(reg_wdata),
        .tick(tick), .periodic(st_q.periodic), .reload_val(st_q.init),
        .cur(cur), .expire(expire)
    );

    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            unique case (reg_addr)
                IDX_CTRL: st_d.en = reg_wdata[0];
                IDX_LVT: begin
                    st_d.vec      = reg_wdata[VW-1:0];
                    st_d.mask     = reg_wdata[LVT_MASK_BIT];
                    st_d.periodic = reg_wdata[LVT_PER_BIT];
                end
                IDX_INIT: st_d.init = reg_wdata;
                IDX_DIV: begin
                    st_d.dlo = reg_wdata[1:0];
                    st_d.dhi = reg_wdata[DIV_HI_BIT];
                end
                IDX_ACK: st_d.pend = 1'b0;
                default: ;
            endcase
        end
        // an expiry in the same cycle as an acknowledge wins
        if (expire && !st_q.mask) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            IDX_CTRL: reg_rdata[0] = st_q.en;
            IDX_LVT: begin
                reg_rdata[VW-1:0]         = st_q.vec;
                reg_rdata[LVT_MASK_BIT]   = st_q.mask;
                reg_rdata[LVT_PER_BIT]    = st_q.periodic;
            end
            IDX_INIT: reg_rdata = st_q.init;
            IDX_CUR:  reg_rdata = cur;
            IDX_DIV: begin
                reg_rdata[1:0]        = st_q.dlo;
                reg_rdata[DIV_HI_BIT] = st_q.dhi;
            end
            default: ;
        endcase
    end

    assign irq_req    = st_q.pend;
    assign irq_vector = st_q.vec;
endmodule

// File: rtl/lcl_tick_timer_chk.sv
module lcl_tick_timer_chk
    import lcl_tmr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic          irq_req,
    input logic [DW-1:0] cur,
    input logic [DW-1:0] init_q,
    input logic          en_q,
    input logic          mask_q,
    input logic          expire
);
    logic init_wr;
    assign init_wr = reg_we && (reg_addr == IDX_INIT);

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (cur == $past(reg_wdata)));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur != '0 && !init_wr) |=>
            (cur == $past(cur) || cur == $past(cur) - 1'b1 || cur == $past(init_q)));

    p_zero_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == '0 && !init_wr) |=> (cur == '0));

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ($past(mask_q) == 1'b0));

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == IDX_ACK && !expire) |=> !irq_req);

    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !init_wr) |=> ($stable(cur) && !$rose(irq_req)));

    p_div_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == IDX_DIV) |-> (reg_rdata[DW-1:4] == '0 && reg_rdata[2] == 1'b0));
endmodule

bind lcl_tick_timer lcl_tick_timer_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .cur(cur), .init_q(st_q.init), .en_q(st_q.en), .mask_q(st_q.mask),
    .expire(expire)
);

// File: tb/lcl_tick_timer_test.sv
module lcl_tick_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd3;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [7:0]  irq_vector;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lcl_tick_timer uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_vector(irq_vector)
    );

    // behavioural reference
    bit          m_en, m_mask, m_per, m_hi, m_pend;
    logic [7:0]  m_vec;
    logic [31:0] m_init, m_cur;
    int          m_lo, m_pre;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_mask = 1; m_per = 0; m_hi = 0; m_pend = 0;
            m_vec = 0; m_init = 0; m_cur = 0; m_lo = 0; m_pre = 0;
        end else begin
            bit ld, rn, tk, ex;
            int code, ratio;
            ld = reg_we && reg_addr == 3'd2;
            rn = m_en && m_cur != 0 && !ld;
            code = m_lo + (m_hi ? 4 : 0);
            ratio = 1 << ((code + 1) % 8);
            tk = rn && ((m_pre % ratio) == ratio - 1);
            ex = tk && m_cur == 1;
            if (ld) m_pre = 0;
            else if (rn) m_pre = (m_pre + 1) % 128;
            if (ld) m_cur = reg_wdata;
            else if (ex) m_cur = m_per ? m_init : 0;
            else if (tk) m_cur = m_cur - 1;
            if (reg_we && reg_addr == 3'd5) m_pend = 0;
            if (ex && !m_mask) m_pend = 1;
            if (reg_we) begin
                case (reg_addr)
                    3'd0: m_en = reg_wdata[0];
                    3'd1: begin m_vec = reg_wdata[7:0]; m_mask = reg_wdata[16]; m_per = reg_wdata[17]; end
                    3'd2: m_init = reg_wdata;
                    3'd4: begin m_lo = int'(reg_wdata[1:0]); m_hi = reg_wdata[3]; end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_rd(input logic [2:0] a);
        case (a)
            3'd0: return {31'd0, m_en};
            3'd1: return {14'd0, m_per, m_mask, 8'd0, m_vec};
            3'd2: return m_init;
            3'd3: return m_cur;
            3'd4: return {28'd0, m_hi, 1'b0, 2'(m_lo)};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        if (a == 3'd3) return "R5";
        if (a == 3'd4) return "R3";
        return "R11";
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic compare();
        if (!rst_n) return;
        chk(irq_req == m_pend, "R8 irq_req", 32'(irq_req), 32'(m_pend));
        chk(irq_vector == m_vec, "R8 irq_vector", 32'(irq_vector), 32'(m_vec));
        chk(reg_rdata == m_rd(reg_addr), rd_tag(reg_addr), reg_rdata, m_rd(reg_addr));
    endtask

    task automatic step(input bit we, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        compare();
        reg_we = we; reg_addr = a; reg_wdata = d;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step(1'b1, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd3, 32'd0);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        step(1'b0, a, 32'd0);
        #1 v = reg_rdata;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd1, v); chk(v == 32'h0001_0000, "R1 entry", v, 32'h0001_0000);
        rd(3'd3, v); chk(v == 0, "R1 live count", v, 0);
        rd(3'd4, v); chk(v == 0, "R1 divide", v, 0);
        chk(irq_req == 0, "R1 irq", 32'(irq_req), 0);

        // R10 disabled timer holds
        wr(3'd2, 32'd5); idle(3); rd(3'd3, v);
        chk(v == 5, "R10 frozen count", v, 5);

        wr(3'd0, 32'd1);
        wr(3'd1, 32'h41);
        // R2 code 7 -> divide by 1
        wr(3'd4, 32'hB); wr(3'd2, 32'd100); idle(5); rd(3'd3, v);
        chk(v == 95, "R2 div1", v, 95);
        // R2 code 0 -> divide by 2
        wr(3'd4, 32'h0); wr(3'd2, 32'd100); idle(5); rd(3'd3, v);
        chk(v == 98, "R2 div2", v, 98);
        // R2 code 3 -> divide by 16
        wr(3'd4, 32'h3); wr(3'd2, 32'd100); idle(32); rd(3'd3, v);
        chk(v == 98, "R2 div16", v, 98);
        // R3 reserved bits
        wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, v);
        chk(v == 32'hB, "R3 readback", v, 32'hB);

        // R6 / R8 single-shot expiry
        wr(3'd4, 32'hB); wr(3'd2, 32'd3); idle(3); rd(3'd3, v);
        chk(v == 0, "R6 expired", v, 0);
        chk(irq_req == 1, "R8 raised", 32'(irq_req), 1);
        chk(irq_vector == 8'h41, "R8 vector", 32'(irq_vector), 32'h41);
        idle(4); rd(3'd3, v);
        chk(v == 0, "R6 held", v, 0);

        // R9 acknowledge
        wr(3'd5, 32'hDEAD_BEEF); rd(3'd3, v);
        chk(irq_req == 0, "R9 cleared", 32'(irq_req), 0);

        // R8 masked expiry
        wr(3'd1, 32'h0001_0041); wr(3'd2, 32'd2); idle(2); rd(3'd3, v);
        chk(v == 0 && irq_req == 0, "R8 masked", 32'(irq_req), 0);

        // R7 reload mode
        wr(3'd1, 32'h0002_0052); wr(3'd2, 32'd4); idle(4); rd(3'd3, v);
        chk(v == 4, "R7 reload", v, 4);
        chk(irq_req == 1 && irq_vector == 8'h52, "R7 request", 32'(irq_vector), 32'h52);

        // R11 readback
        rd(3'd2, v); chk(v == 4, "R11 start count", v, 4);
        rd(3'd1, v); chk(v == 32'h0002_0052, "R11 entry", v, 32'h0002_0052);
        rd(3'd0, v); chk(v == 1, "R11 control", v, 1);

        // R10 disable mid-run
        wr(3'd5, 0); wr(3'd0, 32'd0); rd(3'd3, v); idle(10); rd(3'd3, v2);
        chk(v == v2, "R10 freeze", v2, v);
        chk(irq_req == 0, "R10 no request", 32'(irq_req), 0);

        // R4 zero stops
        wr(3'd0, 32'd1); wr(3'd2, 32'd0); idle(5); rd(3'd3, v);
        chk(v == 0, "R4 stopped", v, 0);

        // random traffic, model compared each cycle
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 6) idle(1);
            else begin
                logic [2:0] a;
                logic [31:0] d;
                a = 3'($urandom_range(0, 5));
                d = $urandom;
                if (a == 3'd2) d = 32'($urandom_range(0, 40));
                if (a == 3'd0) d = ($urandom_range(0, 7) != 0) ? 32'd1 : 32'd0;
                if (a == 3'd4 && $urandom_range(0, 1) == 1) d = 32'hB;
                wr(a, d);
            end
        end
        idle(2);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule